// File: doc/BRIEF.md
# RAS Error Record Node

This block gathers error events from a set of hardware sources and gives each source an indexed error record. Every record keeps a small status word and an 8-bit corrected-error counter. Software reaches all of it through a simple 64-bit register port. Record 0's control word is the only control word, and it acts for the whole node. It gates detection and enables the two interrupt classes. An uncorrected error interrupts at once. A corrected error only bumps its record's counter, and it interrupts only when the counter reaches its top.

Firmware can preload a counter to set how many corrected errors pass before the next interrupt. It can also fake an error on any record by writing that record's index to an injection register. A group status word has one bit per record. Software scans it from bit 0 upward, services the lowest pending record, and then clears that record's status bits by writing ones to them.

Each record's type (corrected or uncorrected) is fixed at build time. The parameter `NREC` may be anywhere from 1 to 32.

Top module: `ras_err_node`

## Requirements
- R1: After reset every control, status and counter field is zero, `irq` is low and `reg_rdata` is zero.
- R2: Offset 0x008 holds the node control word. Bit 0 is detection enable, bit 2 is the uncorrected interrupt enable and bit 8 is the corrected interrupt enable. Other bits read zero. The control offset 0x008+64·n of any record n>0 reads zero and ignores writes.
- R3: Offset 0xFC8 reads as `NREC`. Every read returns its data in `reg_rdata` on the cycle after the cycle in which `reg_rd` was high.
- R4: An event on an uncorrected record sets status bit 0 (valid) and bit 1 (uncorrected) at 0x010+64·n. If control bit 2 is set, `irq` is high from the next cycle. `irq` stays high for as long as that status is pending.
- R5: An event on a corrected record sets status bits 0 and 2 and increments the counter in bits [39:32] of the misc word at 0x020+64·n. The counter saturates at 0xFF.
- R6: A corrected event that finds the counter at 0xFE or 0xFF sets status bit 3 (threshold reached). Only that bit, together with control bit 8, raises `irq`. A counter written with 0xFE or 0xFF therefore interrupts on the next corrected event.
- R7: The group status word at 0xE00 has bit n equal to record n's valid bit. It is read-only.
- R8: Writing ones to status bits [31:0] clears those bits. Clearing the valid bit clears the group status bit, and `irq` drops once nothing interrupt-worthy is pending.
- R9: Writing a value v below `NREC` to offset 0x07C raises one event of record v's configured type. Any value at or above `NREC` is ignored.
- R10: While control bit 0 is clear, source inputs and injections change no status, no counter and no group bit.
- R11: Reads of unimplemented offsets (including 0x07C) return zero. Writes to them, and to the group or ID words, change nothing.
- R12: If a software write and an event hit the same record in the same cycle, the event is applied after the write. A cleared status is set again, and the counter increments from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered |
| err_src | input | NREC | Per-record error event, one pulse per error |
| irq | output | 1 | Level interrupt, registered |

## Verification
All state changes land on the clock edge that samples the stimulus. A status or counter change is therefore visible to a read issued one cycle later, and `irq` follows on the cycle right after the event or clearing write. Read data appears one cycle after the read strobe. The bench drives on falling edges. The driver queues each expected read value when it issues the read. The monitor compares that value on the falling edge that follows the next rising edge. Interrupt checks sample `irq` on the falling edge right after the stimulus cycle.

// File: rtl/ras_node_pkg.sv
package ras_node_pkg;
  localparam int DW = 64;
  localparam int AW = 12;

  localparam logic [AW-1:0] OFS_INJ   = 12'h07C;
  localparam logic [AW-1:0] OFS_GSR   = 12'hE00;
  localparam logic [AW-1:0] OFS_DEVID = 12'hFC8;

  localparam logic [5:0] SUB_CTRL = 6'h08;
  localparam logic [5:0] SUB_STS  = 6'h10;
  localparam logic [5:0] SUB_MISC = 6'h20;

  localparam int CTL_DET = 0;
  localparam int CTL_UEI = 2;
  localparam int CTL_CEI = 8;

  localparam int CNT_W  = 8;
  localparam int CNT_LO = 32;
  localparam int ST_W   = 4;

  typedef struct packed {
    logic thr;   // bit 3: counter threshold reached
    logic ce;    // bit 2: corrected error seen
    logic ue;    // bit 1: uncorrected error seen
    logic v;     // bit 0: record valid
  } rec_sts_t;

  typedef enum logic [2:0] {
    K_NONE, K_CTRL, K_STS, K_MISC, K_GSR, K_DEVID, K_INJ
  } reg_kind_t;
endpackage

// File: rtl/ras_node_dec.sv
module ras_node_dec
  import ras_node_pkg::*;
#(
  parameter int NREC = 8,
  localparam int IX_W = (NREC > 1) ? $clog2(NREC) : 1
) (
  input  logic [AW-1:0]   addr,
  output reg_kind_t       kind,
  output logic [IX_W-1:0] idx
);
  logic [5:0] rec_full;
  logic [5:0] sub;
  logic       rec_ok;

  always_comb begin
    rec_full = addr[AW-1:6];
    sub      = addr[5:0];
    rec_ok   = (rec_full < 6'(NREC));
    idx      = rec_full[IX_W-1:0];
    kind     = K_NONE;
    if (addr == OFS_INJ)                            kind = K_INJ;
    else if (addr == OFS_GSR)                       kind = K_GSR;
    else if (addr == OFS_DEVID)                     kind = K_DEVID;
    else if (rec_ok && sub == SUB_CTRL && rec_full == 6'd0) kind = K_CTRL;
    else if (rec_ok && sub == SUB_STS)              kind = K_STS;
    else if (rec_ok && sub == SUB_MISC)             kind = K_MISC;
  end
endmodule

// File: rtl/ras_node_rec.sv
module ras_node_rec
  import ras_node_pkg::*;
#(
  parameter bit IS_CE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             sts_wr,
  input  logic [ST_W-1:0]  sts_clr,
  input  logic             misc_wr,
  input  logic [CNT_W-1:0] misc_val,
  output rec_sts_t         sts_q,
  output rec_sts_t         sts_d,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_THR = CNT_MAX - 1'b1;

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] cnt_d;
  rec_sts_t         after_sw;
  rec_sts_t         ev_set;
  logic             bump;

  generate
    if (IS_CE) begin : g_ce
      always_comb begin
        ev_set     = '0;
        ev_set.v   = evt;
        ev_set.ce  = evt;
        ev_set.thr = evt && (base >= CNT_THR);
        bump       = evt && (base != CNT_MAX);
      end
    end else begin : g_ue
      always_comb begin
        ev_set    = '0;
        ev_set.v  = evt;
        ev_set.ue = evt;
        bump      = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    after_sw = sts_wr ? (sts_q & ~rec_sts_t'(sts_clr)) : sts_q;
    sts_d    = after_sw | ev_set;
    base     = misc_wr ? misc_val : cnt_q;
    cnt_d    = bump ? base + 1'b1 : base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      cnt_q <= '0;
    end else begin
      sts_q <= sts_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ras_err_node.sv
module ras_err_node
  import ras_node_pkg::*;
#(
  parameter int          NREC    = 8,
  parameter logic [63:0] CE_MASK = 64'h0000_0000_0000_00F0,
  localparam int IX_W = (NREC > 1) ? $clog2(NREC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NREC-1:0] err_src,
  output logic            irq
);
  reg_kind_t       kind;
  logic [IX_W-1:0] idx;
  logic            det_q, uei_q, cei_q;
  logic            det_d, uei_d, cei_d;
  logic            inj_ok;
  logic [NREC-1:0] evt, gsr, ue_vec, ue_nx, thr_nx;
  rec_sts_t        sts_q [NREC];
  rec_sts_t        sts_d [NREC];
  logic [CNT_W-1:0] cnt_q [NREC];
  logic [DW-1:0]   rd_d;

  ras_node_dec #(.NREC(NREC)) u_dec (
    .addr (reg_addr),
    .kind (kind),
    .idx  (idx)
  );

  assign inj_ok = reg_wr && (kind == K_INJ) && (reg_wdata < 64'(NREC));

  for (genvar n = 0; n < NREC; n++) begin : g_rec
    logic inj_hit;
    assign inj_hit   = inj_ok && (reg_wdata[5:0] == 6'(n));
    assign evt[n]    = det_q && (err_src[n] || inj_hit);
    assign gsr[n]    = sts_q[n].v;
    assign ue_vec[n] = sts_q[n].ue;
    assign ue_nx[n]  = sts_d[n].ue;
    assign thr_nx[n] = sts_d[n].thr;

    ras_node_rec #(.IS_CE(CE_MASK[n])) u_rec (
      .clk      (clk),
      .rst      (rst),
      .evt      (evt[n]),
      .sts_wr   (reg_wr && kind == K_STS && idx == IX_W'(n)),
      .sts_clr  (reg_wdata[ST_W-1:0]),
      .misc_wr  (reg_wr && kind == K_MISC && idx == IX_W'(n)),
      .misc_val (reg_wdata[CNT_LO+CNT_W-1:CNT_LO]),
      .sts_q    (sts_q[n]),
      .sts_d    (sts_d[n]),
      .cnt_q    (cnt_q[n])
    );
  end

  always_comb begin
    det_d = det_q;
    uei_d = uei_q;
    cei_d = cei_q;
    if (reg_wr && kind == K_CTRL) begin
      det_d = reg_wdata[CTL_DET];
      uei_d = reg_wdata[CTL_UEI];
      cei_d = reg_wdata[CTL_CEI];
    end
  end

  always_comb begin
    rd_d = '0;
    case (kind)
      K_CTRL: begin
        rd_d[CTL_DET] = det_q;
        rd_d[CTL_UEI] = uei_q;
        rd_d[CTL_CEI] = cei_q;
      end
      K_STS:   rd_d[ST_W-1:0] = sts_q[idx];
      K_MISC:  rd_d[CNT_LO+CNT_W-1:CNT_LO] = cnt_q[idx];
      K_GSR:   rd_d[NREC-1:0] = gsr;
      K_DEVID: rd_d = 64'(NREC);
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      det_q     <= 1'b0;
      uei_q     <= 1'b0;
      cei_q     <= 1'b0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      det_q     <= det_d;
      uei_q     <= uei_d;
      cei_q     <= cei_d;
      irq       <= (uei_d && |ue_nx) || (cei_d && |thr_nx);
      reg_rdata <= reg_rd ? rd_d : '0;
    end
  end
endmodule

// File: rtl/ras_err_node_chk.sv
module ras_err_node_chk #(
  parameter int NREC = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            irq,
  input logic            reg_wr,
  input logic [63:0]     reg_rdata,
  input logic            det_q,
  input logic            uei_q,
  input logic            cei_q,
  input logic [NREC-1:0] gsr,
  input logic [NREC-1:0] ue_vec
);
  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && reg_rdata == 64'd0 && gsr == '0));

  assert_ue_irq_R4: assert property (@(posedge clk) disable iff (rst)
    (uei_q && (ue_vec != '0)) |-> irq);

  assert_irq_has_pending_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (gsr != '0));

  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
    (!uei_q && !cei_q) |-> !irq);

  assert_detect_off_R10: assert property (@(posedge clk) disable iff (rst)
    (!det_q && !reg_wr) |=> (gsr == $past(gsr)));
endmodule

bind ras_err_node ras_err_node_chk #(.NREC(NREC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq       (irq),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .det_q     (det_q),
  .uei_q     (uei_q),
  .cei_q     (cei_q),
  .gsr       (gsr),
  .ue_vec    (ue_vec)
);

// File: tb/ras_err_node_tb.sv
module ras_err_node_tb;
  localparam int NREC = 8;
  localparam logic [63:0] CLR = 64'hFFFF_FFFF;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reg_wr = 1'b0;
  logic            reg_rd = 1'b0;
  logic [11:0]     reg_addr = '0;
  logic [63:0]     reg_wdata = '0;
  logic [63:0]     reg_rdata;
  logic [NREC-1:0] err_src = '0;
  logic            irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit pend = 1'b0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  ras_err_node #(.NREC(NREC), .CE_MASK(64'hF0)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .err_src(err_src), .irq(irq)
  );

  // monitor: a read sampled at a rising edge is compared on the next falling edge
  always @(posedge clk) pend <= reg_rd;
  always @(negedge clk) begin
    if (pend) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected read data act=%h exp=none", reg_rdata);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          bad++;
          $display("FAIL %s act=%h exp=%h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wr_src(input logic [11:0] a, input logic [63:0] d, input logic [NREC-1:0] m);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d; err_src = m;
    @(negedge clk); reg_wr = 1'b0; err_src = '0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [63:0] e, input string t);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic [NREC-1:0] m);
    @(negedge clk); err_src = m;
    @(negedge clk); err_src = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s irq act=%b exp=%b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_irq(1'b0, "R1 reset");
    rd(12'h008, 64'h0, "R1 ctrl after reset");
    rd(12'h010, 64'h0, "R1 status after reset");
    rd(12'h020, 64'h0, "R1 misc after reset");
    rd(12'hE00, 64'h0, "R1 group after reset");
    // R2 control word
    wr(12'h008, '1);
    rd(12'h008, 64'h105, "R2 ctrl readback");
    wr(12'h048, '1);
    rd(12'h048, 64'h0, "R2 ctrl of record 1");
    // R3 id word
    rd(12'hFC8, 64'd8, "R3 record count");
    // R4 uncorrected error
    pulse(8'h02);
    chk_irq(1'b1, "R4 ue irq");
    rd(12'h050, 64'h3, "R4 ue status");
    rd(12'hE00, 64'h2, "R7 group bit");
    chk_irq(1'b1, "R4 irq level held");
    // R8 clear
    wr(12'h050, CLR);
    chk_irq(1'b0, "R8 irq drops");
    rd(12'h050, 64'h0, "R8 status cleared");
    rd(12'hE00, 64'h0, "R8 group cleared");
    // R4 with uncorrected interrupt disabled
    wr(12'h008, 64'h101);
    pulse(8'h04);
    chk_irq(1'b0, "R4 ue masked");
    rd(12'hE00, 64'h4, "R7 group bit 2");
    wr(12'h090, CLR);
    // R5 corrected counting
    wr(12'h008, 64'h105);
    pulse(8'h10);
    pulse(8'h10);
    chk_irq(1'b0, "R5 ce below threshold");
    rd(12'h120, 64'h2_0000_0000, "R5 counter 2");
    rd(12'h110, 64'h5, "R5 ce status");
    wr(12'h110, CLR);
    // R6 preload threshold
    wr(12'h120, 64'h1234_56FE_0000_ABCD);
    rd(12'h120, 64'hFE_0000_0000, "R6 preload readback");
    pulse(8'h10);
    chk_irq(1'b1, "R6 ce threshold irq");
    rd(12'h110, 64'hD, "R6 threshold status");
    rd(12'h120, 64'hFF_0000_0000, "R6 counter at top");
    pulse(8'h10);
    rd(12'h120, 64'hFF_0000_0000, "R5 counter saturates");
    wr(12'h110, CLR);
    chk_irq(1'b0, "R8 ce irq cleared");
    // R9 injection
    wr(12'h07C, 64'd3);
    chk_irq(1'b1, "R9 inject ue irq");
    rd(12'h0D0, 64'h3, "R9 inject ue status");
    wr(12'h0D0, CLR);
    wr(12'h160, 64'hFF_0000_0000);
    wr(12'h07C, 64'd5);
    chk_irq(1'b1, "R9 inject ce at 0xFF irq");
    rd(12'h150, 64'hD, "R9 inject ce status");
    wr(12'h150, CLR);
    wr(12'h07C, 64'd8);
    wr(12'h07C, 64'h1_0000_0003);
    rd(12'hE00, 64'h0, "R9 out of range inject ignored");
    chk_irq(1'b0, "R9 no irq");
    // R10 detection disabled
    wr(12'h008, 64'h104);
    pulse(8'h01);
    wr(12'h07C, 64'd6);
    pulse(8'h10);
    chk_irq(1'b0, "R10 no irq");
    rd(12'hE00, 64'h0, "R10 group unchanged");
    wr(12'h120, 64'h40_0000_0000);
    pulse(8'h10);
    rd(12'h120, 64'h40_0000_0000, "R10 counter unchanged");
    // R11 unimplemented offsets
    wr(12'h030, '1);
    rd(12'h030, 64'h0, "R11 hole reads zero");
    rd(12'h000, 64'h0, "R11 offset 0 zero");
    rd(12'h07C, 64'h0, "R11 inject reads zero");
    wr(12'hE00, '1);
    wr(12'hFC8, 64'h0);
    rd(12'hE00, 64'h0, "R11 group write ignored");
    rd(12'hFC8, 64'd8, "R11 id write ignored");
    rd(12'h008, 64'h104, "R11 ctrl untouched");
    // R12 same-cycle write and event
    wr(12'h008, 64'h105);
    pulse(8'h02);
    wr_src(12'h050, CLR, 8'h02);
    rd(12'h050, 64'h3, "R12 event wins over clear");
    chk_irq(1'b1, "R12 irq stays");
    wr_src(12'h120, 64'h10_0000_0000, 8'h10);
    rd(12'h120, 64'h11_0000_0000, "R12 count from written value");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R3 reads missing act=%0d exp=0", exp_q.size());
    end
    finish_run();
  end
endmodule